// File: doc/BRIEF.md
# Strobed Parallel Bus Register Target

This block lets an FPGA peripheral card answer a slow parallel host bus. The host presents a 6-bit address, 8 data bits, a read/write select and a slot select, and then pulses an I/O strobe. The strobe's edges are slow and asynchronous to the card clock. The block resynchronizes the control lines and filters the strobe, so that a rise or fall only counts once it has held steady for several clocks. For each strobe pulse it accepts, it performs exactly one access to a 64-location register space inside the FPGA.

A write produces a one-cycle write enable, with the captured address and data held on the register-side outputs. A read produces a one-cycle read enable. The returned register value is then driven toward the host, with an output enable for the board-level tristate buffer. Sustained back-to-back writes reach the register space in the host's order, with no drops and no repeats.

Top module: `pbus_target`

## Requirements
- R1: While and after reset, reg_we_o, reg_re_o and data_oe_o are 0, and reg_addr_o and reg_wdata_o are 0.
- R2: strobe_i, slot_en_i and rw_i each pass through two flops before use. A strobe high excursion lasting fewer than FILT_N clocks causes no access.
- R3: An access is accepted once the synchronized strobe has been high for FILT_N consecutive clocks. With FILT_N=3, when strobe_i goes high before clock edge k, the enable is high after edge k+4 and not after edge k+3.
- R4: The block re-arms only after the synchronized strobe has been low for FILT_N consecutive clocks. A low dropout shorter than that, within a held strobe, gives no second access.
- R5: rw_i=0 marks a write, which raises reg_we_o for exactly one cycle. reg_we_o and reg_re_o are never high together.
- R6: reg_addr_o and reg_wdata_o take addr_i and data_i on an accepted access and stay unchanged until the next accepted access.
- R7: A strobe pulse seen while the synchronized slot_en_i is 0 causes no access and leaves reg_addr_o and reg_wdata_o unchanged.
- R8: rw_i=1 marks a read, which raises reg_re_o for one cycle and then presents the register value on data_o. data_oe_o is 1 only while the synchronized slot_en_i, rw_i and strobe_i are all 1.
- R9: Under sustained back-to-back writes with noisy strobe edges, the writes reach the register space in the host's order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Host I/O strobe, active high, asynchronous |
| slot_en_i | input | 1 | Host slot select, active high |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Host address |
| data_i | input | 8 | Host data into the card |
| data_o | output | 8 | Read data toward the host |
| data_oe_o | output | 1 | Enable for the host data driver |
| reg_addr_o | output | 6 | Captured register address |
| reg_wdata_o | output | 8 | Captured write data |
| reg_we_o | output | 1 | One-cycle write enable |
| reg_re_o | output | 1 | One-cycle read enable |
| reg_rdata_i | input | 8 | Register value at reg_addr_o |

## Verification
Clean strobes with a fixed hold measure the acceptance latency exactly. Strobes with bouncing rising and falling edges separate a correct filter from one that counts every bounce. A lone short pulse and a held strobe with a short dropout separate rejection of glitches from wrong re-arming. Strobes with the slot deselected, and read cycles checked against the written contents, cover gating and read direction. A long run of random back-to-back writes with random hold lengths is compared item by item against the host sequence, which exposes any drop, duplicate or reordering.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FILT_N = 3;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pbus_filter.sv
module pbus_filter
  import pbus_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic level_o,
  output logic rise_o
);
  localparam int unsigned CW = (N < 2) ? 1 : $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  lvl_e          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          differ, done;

  assign level_o = (lvl_q == LVL_HIGH);
  assign differ  = (s_i != level_o);
  assign done    = differ && (cnt_q == LAST);
  assign rise_o  = done && (lvl_q == LVL_LOW);

  // level flips only after N consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_LOW;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (done) begin
      lvl_q <= (lvl_q == LVL_LOW) ? LVL_HIGH : LVL_LOW;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_rise_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_rise_needs_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> s_i);
  p_level_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o && s_i) |=> level_o);
endmodule

// File: rtl/pbus_capture.sv
module pbus_capture #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          slot_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  output logic [DW-1:0] rd_data_o
);
  logic accept;
  assign accept = fire_i && slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
    end else begin
      reg_we_o <= accept && !rd_i;
      reg_re_o <= accept && rd_i;
      if (accept) begin
        reg_addr_o  <= addr_i;
        reg_wdata_o <= data_i;
      end
    end
  end

  // register space answers combinationally on reg_addr_o
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       rd_data_o <= '0;
    else if (reg_re_o) rd_data_o <= reg_rdata_i;

  p_we_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  p_we_re_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> ($stable(reg_addr_o) && $stable(reg_wdata_o)));
  p_deselect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !(reg_we_o || reg_re_o));
endmodule

// File: rtl/pbus_target.sv
module pbus_target
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned DATA_BITS = DATA_W,
  parameter int unsigned FILT_LEN  = FILT_N,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 slot_en_i,
  input  logic                 rw_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 data_oe_o,
  output logic [ADDR_BITS-1:0] reg_addr_o,
  output logic [DATA_BITS-1:0] reg_wdata_o,
  output logic                 reg_we_o,
  output logic                 reg_re_o,
  input  logic [DATA_BITS-1:0] reg_rdata_i
);
  localparam int unsigned CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic stb_s, slot_s, rd_s;
  logic stb_lvl, stb_rise;

  pbus_sync #(.W(CTRL_W), .STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({strobe_i, slot_en_i, rw_i}),
    .q_o    (ctrl_s)
  );
  assign {stb_s, slot_s, rd_s} = ctrl_s;

  pbus_filter #(.N(FILT_LEN)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .s_i     (stb_s),
    .level_o (stb_lvl),
    .rise_o  (stb_rise)
  );

  pbus_capture #(.AW(ADDR_BITS), .DW(DATA_BITS)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (stb_rise),
    .slot_i      (slot_s),
    .rd_i        (rd_s),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .rd_data_o   (data_o)
  );

  assign data_oe_o = slot_s && rd_s && stb_s;

  p_we_after_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> stb_lvl);
  p_we_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(slot_s));
  p_oe_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(strobe_i, 2));
endmodule

// File: tb/pbus_target_test.sv
module pbus_target_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe = 1'b0, slot_en = 1'b0, rw = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] data_o, reg_wdata, rdata;
  logic [5:0] reg_addr;
  logic data_oe, reg_we, reg_re;

  logic [7:0]  mem [64];
  logic [13:0] exp_q [$];
  int tests = 0, fails = 0, wr_cnt = 0, re_cnt = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  assign rdata = mem[reg_addr];

  pbus_target uut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .slot_en_i(slot_en),
    .rw_i(rw), .addr_i(addr), .data_i(data), .data_o(data_o),
    .data_oe_o(data_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_rdata_i(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every write enable
  always @(negedge clk) begin
    if (rst_ni && reg_we) begin
      wr_cnt++;
      mem[reg_addr] <= reg_wdata;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R9 write order", {reg_addr, reg_wdata}, e);
      end
    end
    if (rst_ni && reg_re) re_cnt++;
  end

  task automatic host_write(input logic [5:0] a, input logic [7:0] d,
                            input bit slot, input bit noisy, input int hold);
    @(negedge clk);
    addr = a; data = d; rw = 1'b0; slot_en = slot;
    if (slot) exp_q.push_back({a, d});
    if (noisy) begin
      strobe = 1'b1; @(negedge clk);
      strobe = 1'b0; @(negedge clk);
      strobe = 1'b1; repeat (2) @(negedge clk);
      strobe = 1'b0; @(negedge clk);
    end
    strobe = 1'b1; repeat (hold) @(negedge clk);
    if (noisy) begin
      strobe = 1'b0; @(negedge clk);
      strobe = 1'b1; @(negedge clk);
    end
    strobe = 1'b0; repeat (hold) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!reg_we && !reg_re && !data_oe, "R1 enables in reset", {reg_we, reg_re, data_oe}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(reg_addr == 0 && reg_wdata == 0, "R1 outputs after reset", {reg_addr, reg_wdata}, 0);

    // R3: exact latency on a clean strobe
    addr = 6'h11; data = 8'h3c; rw = 1'b0; slot_en = 1'b1;
    repeat (3) @(negedge clk);
    exp_q.push_back({6'h11, 8'h3c});
    strobe = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!reg_we, "R3 not before edge k+4", reg_we, 0);
    @(posedge clk); @(negedge clk);
    chk(reg_we, "R3 write at edge k+4", reg_we, 1);
    chk(reg_addr == 6'h11 && reg_wdata == 8'h3c, "R5 captured fields", {reg_addr, reg_wdata}, {6'h11, 8'h3c});
    @(negedge clk);
    chk(!reg_we, "R5 single-cycle enable", reg_we, 0);
    chk(!data_oe, "R8 no drive on write", data_oe, 0);
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (8) @(negedge clk);

    // R2: short glitch rejected
    w0 = wr_cnt;
    addr = 6'h22; data = 8'h99;
    strobe = 1'b1; repeat (2) @(negedge clk);
    strobe = 1'b0; repeat (10) @(negedge clk);
    chk(wr_cnt == w0, "R2 glitch ignored", wr_cnt - w0, 0);
    chk(reg_addr == 6'h11, "R6 address held", reg_addr, 6'h11);

    // R4: short dropout in held strobe
    w0 = wr_cnt;
    exp_q.push_back({6'h22, 8'h99});
    strobe = 1'b1; repeat (8) @(negedge clk);
    strobe = 1'b0; repeat (2) @(negedge clk);
    strobe = 1'b1; repeat (8) @(negedge clk);
    strobe = 1'b0; repeat (10) @(negedge clk);
    chk(wr_cnt - w0 == 1, "R4 one access per pulse", wr_cnt - w0, 1);

    // R7: slot deselected
    w0 = wr_cnt;
    host_write(6'h3f, 8'hee, 1'b0, 1'b0, 8);
    chk(wr_cnt == w0, "R7 deselected ignored", wr_cnt - w0, 0);
    chk(reg_addr == 6'h22 && reg_wdata == 8'h99, "R7 fields unchanged", {reg_addr, reg_wdata}, {6'h22, 8'h99});

    // R8: read back
    host_write(6'h05, 8'ha5, 1'b1, 1'b1, 8);
    @(negedge clk);
    addr = 6'h05; rw = 1'b1; slot_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!data_oe, "R8 no drive without strobe", data_oe, 0);
    w0 = re_cnt;
    strobe = 1'b1; repeat (9) @(negedge clk);
    chk(data_oe, "R8 drive during read", data_oe, 1);
    chk(data_o == 8'ha5, "R8 read data", data_o, 8'ha5);
    chk(re_cnt - w0 == 1, "R8 one read enable", re_cnt - w0, 1);
    strobe = 1'b0; repeat (4) @(negedge clk);
    chk(!data_oe, "R8 release after strobe", data_oe, 0);
    slot_en = 1'b0; repeat (3) @(negedge clk);
    strobe = 1'b1; repeat (8) @(negedge clk);
    chk(!data_oe, "R8 no drive when deselected", data_oe, 0);
    strobe = 1'b0; repeat (8) @(negedge clk);

    // R9: random back-to-back noisy writes
    w0 = wr_cnt;
    for (int i = 0; i < 40; i++)
      host_write(6'($urandom), 8'($urandom), 1'b1, 1'b1, 4 + int'($urandom_range(0, 5)));
    repeat (10) @(negedge clk);
    chk(wr_cnt - w0 == 40, "R9 write count", wr_cnt - w0, 40);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule